// File: doc/BRIEF.md
# Branch-Target Prefetch Sequence Table

This block steers instruction prefetch. It keeps a small fully associative table of recent control transfers. Each entry pairs the quadword that holds a control-transfer instruction with the quadword that holds its target. Addresses arrive as halfword addresses, and the block forms a quadword address by shifting out the three lowest bits. The table therefore stores only the quadword of a target, even when the target lies partway into that quadword.

Each time the instruction buffer finishes a fetch, the block reports the next quadword to fetch. If the current quadword matches a valid entry, the next quadword is that entry's stored target and the hit flag is raised. Otherwise the next quadword is the sequential successor. The lookup is purely combinational.

The fetch-recovery logic writes the table through a correction port. A taken outcome records or refreshes a transfer, and a not-taken outcome removes it. When the table is full, a new transfer evicts the entry that was written least recently.

Top module: `qrt_top`

## Requirements
- R1: While reset is low, and after it is released, every entry is invalid. Every lookup misses and returns the sequential next quadword until a taken correction is written.
- R2: A quadword address is the halfword address shifted right by three. Bits [2:0] of the fetch address, the correction source and the correction target have no effect on matching or on the stored target.
- R3: On a miss, `next_hit` is 0 and `next_qaddr` is the current quadword plus one, taken modulo 2^(HW_ADDR_W-3). The all-ones quadword wraps to zero.
- R4: On a hit, `next_hit` is 1 and `next_qaddr` is the target quadword stored for the matching source.
- R5: A taken correction whose source quadword is not in the table fills the lowest-numbered invalid entry. No valid entry is displaced while a free one exists.
- R6: A taken correction with a new source quadword, made while all eight entries are valid, replaces the entry whose last write is oldest.
- R7: A taken correction whose source quadword is already present overwrites that entry's target in place and makes it the most recently written. No duplicate entry is created.
- R8: A not-taken correction invalidates the entry that matches its source quadword. If no entry matches, the table is unchanged.
- R9: A correction takes effect at the next rising clock edge. A lookup made in the same cycle as the correction sees the earlier table contents.
- R10: `next_vld` equals `fetch_done` in the same cycle.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_done | input | 1 | Strobe marking the end of an instruction-buffer fetch |
| fetch_haddr | input | HW_ADDR_W | Halfword address within the quadword just fetched |
| fix_en | input | 1 | Correction write strobe |
| fix_taken | input | 1 | Correction outcome: 1 records the transfer, 0 removes it |
| fix_src_haddr | input | HW_ADDR_W | Halfword address of the control-transfer instruction |
| fix_tgt_haddr | input | HW_ADDR_W | Halfword address of the transfer target |
| next_vld | output | 1 | The next-fetch result is valid |
| next_hit | output | 1 | The next fetch comes from a table entry |
| next_qaddr | output | HW_ADDR_W-3 | Quadword address to fetch next |

## Verification
The next-fetch outputs are combinational. The bench therefore drives a new fetch address just after a falling edge and compares the outputs one nanosecond later, inside the same cycle. A correction is due exactly one rising edge after it is driven. The bench's reference model applies the write only after that cycle's comparison, so a lookup made in the same cycle as a correction is checked against the earlier contents. The next cycle's lookup sees the new contents. Directed sequences cover the following cases:
- filling the table
- refreshing an existing entry
- evicting when full
- invalidating an entry, including a correction that matches nothing
- wrap-around at the top of the address space

A randomized phase over a small address pool adds frequent collisions.

// File: rtl/qrt_pkg.sv
package qrt_pkg;
  typedef enum logic [1:0] {
    UPD_NONE    = 2'd0,
    UPD_FILL    = 2'd1,
    UPD_REFRESH = 2'd2,
    UPD_DROP    = 2'd3
  } upd_kind_e;
endpackage

// File: rtl/qrt_cam.sv
module qrt_cam #(
  parameter int ENTRIES = 8,
  parameter int TAG_W   = 21,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [TAG_W-1:0]   look_tag,
  input  logic [TAG_W-1:0]   upd_tag,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [TAG_W-1:0]   wr_tgt,
  input  logic               clr_en,
  input  logic [IDX_W-1:0]   clr_idx,
  output logic               look_hit,
  output logic [TAG_W-1:0]   look_tgt,
  output logic [ENTRIES-1:0] upd_match,
  output logic [ENTRIES-1:0] valid_vec
);
  logic [ENTRIES-1:0] vld_q;
  logic [TAG_W-1:0]   src_q [ENTRIES];
  logic [TAG_W-1:0]   tgt_q [ENTRIES];
  logic [ENTRIES-1:0] look_match;

  // Storage: the source tag written comes from the update tag
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int e = 0; e < ENTRIES; e++) begin
        src_q[e] <= '0;
        tgt_q[e] <= '0;
      end
    end else begin
      if (wr_en) begin
        vld_q[wr_idx] <= 1'b1;
        src_q[wr_idx] <= upd_tag;
        tgt_q[wr_idx] <= wr_tgt;
      end
      if (clr_en) vld_q[clr_idx] <= 1'b0;
    end
  end

  // Per-entry comparators for lookup and for the correction port
  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    assign look_match[e] = vld_q[e] && (src_q[e] == look_tag);
    assign upd_match[e]  = vld_q[e] && (src_q[e] == upd_tag);
  end

  always_comb begin
    look_tgt = '0;
    for (int e = 0; e < ENTRIES; e++)
      if (look_match[e]) look_tgt = look_tgt | tgt_q[e];
  end

  assign look_hit  = |look_match;
  assign valid_vec = vld_q;

  // R1: reset leaves the table empty
  assert_reset_empty_R1: assert property (@(posedge clk)
    !rst_n |=> vld_q == '0);

  // R7: never two valid entries with the same source
  assert_single_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(look_match) && $onehot0(upd_match));

  // R7: a write lands in the chosen slot
  assert_write_lands_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> vld_q[$past(wr_idx)] && src_q[$past(wr_idx)] == $past(upd_tag)
              && tgt_q[$past(wr_idx)] == $past(wr_tgt));

  // R8: a drop invalidates its entry
  assert_drop_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> !vld_q[$past(clr_idx)]);
endmodule

// File: rtl/qrt_recency.sv
module qrt_recency #(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               touch_en,
  input  logic [IDX_W-1:0]   touch_idx,
  input  logic [ENTRIES-1:0] valid_vec,
  output logic [IDX_W-1:0]   victim_idx
);
  localparam logic [IDX_W-1:0] OLDEST = IDX_W'(ENTRIES - 1);

  // rank 0 = most recently written; ranks always form a permutation
  logic [IDX_W-1:0]   rank_q [ENTRIES];
  logic [IDX_W-1:0]   cur_rank;
  logic [ENTRIES-1:0] oldest_vec;
  logic               free_found;

  assign cur_rank = rank_q[touch_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < ENTRIES; e++) rank_q[e] <= IDX_W'(e);
    end else if (touch_en) begin
      for (int e = 0; e < ENTRIES; e++) begin
        if (IDX_W'(e) == touch_idx)  rank_q[e] <= '0;
        else if (rank_q[e] < cur_rank) rank_q[e] <= rank_q[e] + 1'b1;
      end
    end
  end

  for (genvar e = 0; e < ENTRIES; e++) begin : g_old
    assign oldest_vec[e] = (rank_q[e] == OLDEST);
  end

  // Victim: lowest free slot, else the entry written longest ago
  always_comb begin
    free_found = 1'b0;
    victim_idx = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (!free_found && !valid_vec[e]) begin
        free_found = 1'b1;
        victim_idx = IDX_W'(e);
      end
    end
    if (!free_found)
      for (int e = 0; e < ENTRIES; e++)
        if (oldest_vec[e]) victim_idx = IDX_W'(e);
  end

  // R6: exactly one entry carries the oldest rank
  assert_one_oldest_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(oldest_vec) == 1);

  // R7: a touched entry becomes the most recent
  assert_touch_fresh_R7: assert property (@(posedge clk) disable iff (!rst_n)
    touch_en |=> rank_q[$past(touch_idx)] == '0);
endmodule

// File: rtl/qrt_top.sv
module qrt_top #(
  parameter int HW_ADDR_W = 24,
  parameter int ENTRIES   = 8,
  localparam int QW_W     = HW_ADDR_W - 3,
  localparam int IDX_W    = $clog2(ENTRIES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fetch_done,
  input  logic [HW_ADDR_W-1:0] fetch_haddr,
  input  logic                 fix_en,
  input  logic                 fix_taken,
  input  logic [HW_ADDR_W-1:0] fix_src_haddr,
  input  logic [HW_ADDR_W-1:0] fix_tgt_haddr,
  output logic                 next_vld,
  output logic                 next_hit,
  output logic [QW_W-1:0]      next_qaddr
);
  import qrt_pkg::*;

  function automatic logic [QW_W-1:0] qw_of(input logic [HW_ADDR_W-1:0] a);
    return QW_W'(a >> 3);
  endfunction

  function automatic logic [QW_W-1:0] seq_after(input logic [QW_W-1:0] q);
    return q + 1'b1;
  endfunction

  logic [QW_W-1:0]    cur_qw, src_qw, tgt_qw, look_tgt;
  logic               look_hit;
  logic [ENTRIES-1:0] upd_match, valid_vec;
  logic [IDX_W-1:0]   hit_idx, victim_idx, wr_idx;
  logic               wr_en, clr_en;
  upd_kind_e          kind;

  assign cur_qw = qw_of(fetch_haddr);
  assign src_qw = qw_of(fix_src_haddr);
  assign tgt_qw = qw_of(fix_tgt_haddr);

  always_comb begin
    hit_idx = '0;
    for (int e = 0; e < ENTRIES; e++)
      if (upd_match[e]) hit_idx = IDX_W'(e);
  end

  always_comb begin
    kind = UPD_NONE;
    if (fix_en) begin
      if (fix_taken) kind = (|upd_match) ? UPD_REFRESH : UPD_FILL;
      else if (|upd_match) kind = UPD_DROP;
    end
  end

  assign wr_en  = (kind == UPD_FILL) || (kind == UPD_REFRESH);
  assign wr_idx = (kind == UPD_REFRESH) ? hit_idx : victim_idx;
  assign clr_en = (kind == UPD_DROP);

  qrt_cam #(.ENTRIES(ENTRIES), .TAG_W(QW_W)) u_cam (
    .clk(clk), .rst_n(rst_n),
    .look_tag(cur_qw), .upd_tag(src_qw),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_tgt(tgt_qw),
    .clr_en(clr_en), .clr_idx(hit_idx),
    .look_hit(look_hit), .look_tgt(look_tgt),
    .upd_match(upd_match), .valid_vec(valid_vec)
  );

  qrt_recency #(.ENTRIES(ENTRIES)) u_rec (
    .clk(clk), .rst_n(rst_n),
    .touch_en(wr_en), .touch_idx(wr_idx),
    .valid_vec(valid_vec), .victim_idx(victim_idx)
  );

  assign next_vld   = fetch_done;
  assign next_hit   = look_hit;
  assign next_qaddr = look_hit ? look_tgt : seq_after(cur_qw);

  // R5: a fill goes to a free slot whenever one exists
  assert_fill_prefers_free_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == UPD_FILL && !(&valid_vec)) |-> !valid_vec[victim_idx]);

  // R8: after a drop, that source no longer matches
  assert_drop_gone_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> (u_cam.upd_match == '0) || !$stable(fix_src_haddr[HW_ADDR_W-1:3])
               || ($past(hit_idx) != hit_idx));
endmodule

// File: tb/tb_qrt_top.sv
`timescale 1ns/1ps
module tb_qrt_top;
  localparam int HW = 24;
  localparam int QW = HW - 3;
  localparam int N  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fetch_done = 1'b0;
  logic [HW-1:0] fetch_haddr = '0;
  logic fix_en = 1'b0, fix_taken = 1'b0;
  logic [HW-1:0] fix_src_haddr = '0, fix_tgt_haddr = '0;
  logic next_vld, next_hit;
  logic [QW-1:0] next_qaddr;

  qrt_top #(.HW_ADDR_W(HW), .ENTRIES(N)) dut (
    .clk(clk), .rst_n(rst_n), .fetch_done(fetch_done), .fetch_haddr(fetch_haddr),
    .fix_en(fix_en), .fix_taken(fix_taken), .fix_src_haddr(fix_src_haddr),
    .fix_tgt_haddr(fix_tgt_haddr), .next_vld(next_vld), .next_hit(next_hit),
    .next_qaddr(next_qaddr)
  );

  always #2 clk = ~clk;

  int n_run = 0, n_fail = 0;
  bit finished = 0;

  // Reference model: recency kept as write timestamps
  bit          m_vld [N];
  logic [QW-1:0] m_src [N];
  logic [QW-1:0] m_tgt [N];
  longint      m_stamp [N];
  longint      now = 0;

  task automatic model_clear();
    for (int i = 0; i < N; i++) begin
      m_vld[i] = 0; m_src[i] = '0; m_tgt[i] = '0; m_stamp[i] = 0;
    end
  endtask

  task automatic model_lookup(input logic [QW-1:0] q, output bit hit, output logic [QW-1:0] nq);
    hit = 0; nq = q + 1'b1;
    for (int i = 0; i < N; i++)
      if (m_vld[i] && m_src[i] == q) begin hit = 1; nq = m_tgt[i]; end
  endtask

  task automatic model_update(input bit taken, input logic [QW-1:0] s, input logic [QW-1:0] t);
    int slot = -1;
    now++;
    for (int i = 0; i < N; i++) if (m_vld[i] && m_src[i] == s) slot = i;
    if (!taken) begin
      if (slot >= 0) m_vld[slot] = 0;
      return;
    end
    if (slot < 0)
      for (int i = N - 1; i >= 0; i--) if (!m_vld[i]) slot = i;
    if (slot < 0) begin
      slot = 0;
      for (int i = 1; i < N; i++) if (m_stamp[i] < m_stamp[slot]) slot = i;
    end
    m_vld[slot] = 1; m_src[slot] = s; m_tgt[slot] = t; m_stamp[slot] = now;
  endtask

  // One cycle: drive after negedge, compare 1 ns later, model the next edge
  task automatic step(input bit fd, input logic [HW-1:0] fa, input bit fe, input bit ft,
                      input logic [HW-1:0] fs, input logic [HW-1:0] fg, input string tag);
    bit eh; logic [QW-1:0] eq; string t;
    @(negedge clk);
    fetch_done = fd; fetch_haddr = fa;
    fix_en = fe; fix_taken = ft; fix_src_haddr = fs; fix_tgt_haddr = fg;
    #1;
    model_lookup(fa[HW-1:3], eh, eq);
    t = (tag == "") ? (eh ? "R4" : "R3") : tag;
    n_run++;
    if (next_vld !== fd || next_hit !== eh || next_qaddr !== eq) begin
      n_fail++;
      $display("FAIL %s: vld/hit/qaddr got %0b/%0b/%h expected %0b/%0b/%h",
               t, next_vld, next_hit, next_qaddr, fd, eh, eq);
    end
    if (fe && rst_n) model_update(ft, fs[HW-1:3], fg[HW-1:3]);
  endtask

  function automatic logic [HW-1:0] ha(input logic [QW-1:0] q, input logic [2:0] lo);
    return {q, lo};
  endfunction

  function automatic logic [QW-1:0] src_of(input int i);
    return QW'(32'h100 + i);
  endfunction

  initial begin
    #(4 * 200000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    model_clear();
    // R1: during reset the table is empty; a write attempt has no effect
    step(1, ha(21'h10, 3'd5), 1, 1, ha(21'h10, 0), ha(21'h20, 0), "R1");
    step(1, ha(21'h10, 3'd0), 0, 0, '0, '0, "R1");
    @(negedge clk); rst_n = 1'b1;
    step(1, ha(21'h10, 3'd2), 0, 0, '0, '0, "R1");
    // R3: wrap at the top quadword
    step(1, ha({QW{1'b1}}, 3'd7), 0, 0, '0, '0, "R3");
    // R9: same-cycle lookup sees the old table
    step(1, ha(src_of(0), 3'd0), 1, 1, ha(src_of(0), 3'd6), ha(21'h2000, 3'd3), "R9");
    // R2: different low bits still hit; stored target drops its low bits
    step(1, ha(src_of(0), 3'd7), 0, 0, '0, '0, "R2");
    // R5: fill the remaining slots
    for (int i = 1; i < N; i++)
      step(0, '0, 1, 1, ha(src_of(i), 3'(i)), ha(QW'(32'h2000 + i), 3'd0), "R5");
    for (int i = 0; i < N; i++)
      step(1, ha(src_of(i), 3'd1), 0, 0, '0, '0, "R4");
    // R7: refresh entry 0 in place
    step(0, '0, 1, 1, ha(src_of(0), 3'd2), ha(21'h3333, 3'd4), "R7");
    step(1, ha(src_of(0), 3'd0), 0, 0, '0, '0, "R7");
    // R6: new source evicts the oldest write (source 1)
    step(0, '0, 1, 1, ha(src_of(8), 3'd0), ha(21'h4444, 3'd0), "R6");
    step(1, ha(src_of(1), 3'd0), 0, 0, '0, '0, "R6");
    step(1, ha(src_of(8), 3'd0), 0, 0, '0, '0, "R6");
    step(1, ha(src_of(0), 3'd0), 0, 0, '0, '0, "R6");
    // R8: not-taken invalidates; an unmatched one changes nothing
    step(0, '0, 1, 0, ha(src_of(3), 3'd0), '0, "R8");
    step(1, ha(src_of(3), 3'd0), 0, 0, '0, '0, "R8");
    step(0, '0, 1, 0, ha(21'h7777, 3'd0), '0, "R8");
    for (int i = 4; i < N; i++)
      step(1, ha(src_of(i), 3'd0), 0, 0, '0, '0, "R8");
    // R5: refill goes to the freed slot, evicting nobody
    step(0, '0, 1, 1, ha(src_of(9), 3'd0), ha(21'h5555, 3'd0), "R5");
    step(1, ha(src_of(2), 3'd0), 0, 0, '0, '0, "R5");
    step(1, ha(src_of(9), 3'd0), 0, 0, '0, '0, "R5");
    // R10: no strobe, no valid
    step(0, ha(src_of(9), 3'd0), 0, 0, '0, '0, "R10");
    // Random collisions against the model
    for (int k = 0; k < 600; k++) begin
      logic [QW-1:0] a, s, g;
      a = QW'(32'h500 + ($urandom % 12));
      s = QW'(32'h500 + ($urandom % 12));
      g = QW'($urandom);
      step(1'($urandom), ha(a, 3'($urandom)), ($urandom % 3) != 0, ($urandom % 4) != 0,
           ha(s, 3'($urandom)), ha(g, 3'($urandom)), "");
    end
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule